// File: doc/BRIEF.md
# Read-Control Handshake Machine with Flip-Flop Outputs

This block sequences a single read transaction. A start request leaves the idle phase. The block then holds a read-active output high through a read phase and one or more delay phases. Each extra delay phase is inserted while a wait request is high. A one-cycle done strobe closes the transaction before the block goes back to idle. Both outputs are taken straight from flip-flops. They change only at a clock edge, never glitch, and leave the whole next cycle to the logic they feed.

A parameter selects how the output flip-flops are built. With `OUT_STYLE = 0`, the output values that belong to the next phase are worked out together with that phase. They are loaded into their own flip-flops on the same edge as the phase register. With `OUT_STYLE = 1`, the phase register is a three-bit code laid out as {read-active, done, spare}, with idle = 000, read = 100, delay = 101 and done = 010. The two outputs are then simply two of the state bits. If this register ever holds an unused code, the next state is idle. Both builds give the same outputs in every cycle.

Top module: `hs_reg_fsm`

## Requirements
- R1: Reset is synchronous and active low. After any clock edge at which `rst_n` is 0, `rd_active` = 0 and `done_strobe` = 0, and the machine is idle.
- R2: While idle, a rising clock edge with `start_req` = 1 makes `rd_active` = 1 from that edge on. With `start_req` = 0 the machine stays idle with both outputs 0.
- R3: The read phase lasts exactly one cycle and is always followed by the delay phase, whatever the inputs. `rd_active` stays 1 across that edge.
- R4: In the delay phase, an edge with `wait_req` = 1 returns to the read phase, so `rd_active` stays 1 and `done_strobe` stays 0. An edge with `wait_req` = 0 moves to the done phase, so `rd_active` = 0 and `done_strobe` = 1.
- R5: The done phase lasts exactly one cycle and then returns to idle (both outputs 0), whatever `start_req` and `wait_req` are.
- R6: `rd_active` and `done_strobe` are never 1 in the same cycle, and each is driven directly by a flip-flop.
- R7: Builds with `OUT_STYLE` = 0 and `OUT_STYLE` = 1 give identical `rd_active` and `done_strobe` in every cycle for the same input and reset sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to begin a read transaction |
| wait_req | input | 1 | Insert another read/delay pass while high in the delay phase |
| rd_active | output | 1 | High during the read and delay phases (registered) |
| done_strobe | output | 1 | One-cycle pulse in the done phase (registered) |

## Verification
The bench builds the block twice side by side: once with `OUT_STYLE = 0` (registered next-outputs) and once with `OUT_STYLE = 1` (outputs as state bits). Both copies get the same reset and input sequence. Each copy is compared every cycle against a phase model in the bench, and the two copies are also compared with each other. This covers every transition out of each phase, long chains of wait-state loops, a start request held during the done phase, and a reset asserted in the middle of a transaction, for both ways of building the output flip-flops.

// File: rtl/hsf_pkg.sv
// Package: shared phase type, next-phase rule and state-bit codes for the
// read-control handshake machine. Assumes a two-input (start, wait) control.
package hsf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_DELAY = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;

    // Width of the state-bit encoding {rd, done, spare}
    localparam int SB_W      = 3;
    localparam int SB_RD_BIT = 2;
    localparam int SB_DN_BIT = 1;

    localparam logic [SB_W-1:0] SB_IDLE  = 3'b000;
    localparam logic [SB_W-1:0] SB_READ  = 3'b100;
    localparam logic [SB_W-1:0] SB_DELAY = 3'b101;
    localparam logic [SB_W-1:0] SB_DONE  = 3'b010;

    // Next phase from the present phase and the two requests
    function automatic phase_t phase_step(phase_t cur, logic start, logic waitr);
        phase_t nxt;
        case (cur)
            PH_IDLE:  nxt = start ? PH_READ : PH_IDLE;
            PH_READ:  nxt = PH_DELAY;
            PH_DELAY: nxt = waitr ? PH_READ : PH_DONE;
            PH_DONE:  nxt = PH_IDLE;
            default:  nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

    // Read-active value that belongs to a phase
    function automatic logic phase_rd(phase_t ph);
        return (ph == PH_READ) || (ph == PH_DELAY);
    endfunction

    // Done-strobe value that belongs to a phase
    function automatic logic phase_dn(phase_t ph);
        return ph == PH_DONE;
    endfunction

endpackage

// File: rtl/hsf_next_out.sv
// Module: hsf_next_out
// Output style 0. A binary phase register plus two output flip-flops that
// are loaded with the values decoded from the next phase on the same edge.
// Assumes synchronous active-low reset; outputs come straight from flops.
module hsf_next_out
    import hsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic wait_req,
    output logic rd_active,
    output logic done_strobe
);

    phase_t ph_q;
    phase_t ph_d;
    logic   rd_d;
    logic   dn_d;
    logic   rd_q;
    logic   dn_q;

    // Next phase and the outputs that belong to it
    always_comb begin
        ph_d = phase_step(ph_q, start_req, wait_req);
        rd_d = phase_rd(ph_d);
        dn_d = phase_dn(ph_d);
    end

    // Phase register and output registers, loaded together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
            rd_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            rd_q <= rd_d;
            dn_q <= dn_d;
        end
    end

    assign rd_active   = rd_q;
    assign done_strobe = dn_q;

endmodule

// File: rtl/hsf_state_bits.sv
// Module: hsf_state_bits
// Output style 1. A three-bit state register coded {rd, done, spare} so that
// each output is one state bit. Unused codes step to idle on the next edge.
// Assumes synchronous active-low reset.
module hsf_state_bits
    import hsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic wait_req,
    output logic rd_active,
    output logic done_strobe
);

    logic [SB_W-1:0] st_q;
    logic [SB_W-1:0] st_d;

    // Next-state decode on the coded register, with recovery to idle
    always_comb begin
        case (st_q)
            SB_IDLE:  st_d = start_req ? SB_READ : SB_IDLE;
            SB_READ:  st_d = SB_DELAY;
            SB_DELAY: st_d = wait_req ? SB_READ : SB_DONE;
            SB_DONE:  st_d = SB_IDLE;
            default:  st_d = SB_IDLE;
        endcase
    end

    // Coded state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SB_IDLE;
        else        st_q <= st_d;
    end

    assign rd_active   = st_q[SB_RD_BIT];
    assign done_strobe = st_q[SB_DN_BIT];

endmodule

// File: rtl/hs_reg_fsm.sv
// Module: hs_reg_fsm
// Read-control handshake machine with flip-flop outputs. OUT_STYLE picks the
// registered next-output build (0) or the state-bit build (1).
// Assumes a single clock and synchronous active-low reset.
module hs_reg_fsm #(
    parameter int OUT_STYLE = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic wait_req,
    output logic rd_active,
    output logic done_strobe
);

    // Select the output-register build
    generate
        if (OUT_STYLE == 0) begin : g_next_out
            hsf_next_out u_core (
                .clk         (clk),
                .rst_n       (rst_n),
                .start_req   (start_req),
                .wait_req    (wait_req),
                .rd_active   (rd_active),
                .done_strobe (done_strobe)
            );
        end else begin : g_state_bits
            hsf_state_bits u_core (
                .clk         (clk),
                .rst_n       (rst_n),
                .start_req   (start_req),
                .wait_req    (wait_req),
                .rd_active   (rd_active),
                .done_strobe (done_strobe)
            );
        end
    endgenerate

endmodule

// File: rtl/hsf_chk.sv
// Module: hsf_chk
// Assertion checker bound to hs_reg_fsm; observes ports only.
module hsf_chk (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic wait_req,
    input logic rd_active,
    input logic done_strobe
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!rd_active && !done_strobe)); // R1
    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_active && !done_strobe && start_req) |=> rd_active); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_active && !done_strobe && !start_req) |=> (!rd_active && !done_strobe)); // R2
    AST_READ_TO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_active) |=> rd_active); // R3
    AST_DONE_FROM_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_strobe) |-> ($past(rd_active) && !$past(wait_req))); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_strobe |=> (!done_strobe && !rd_active)); // R5
    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_active && done_strobe)); // R6

endmodule

bind hs_reg_fsm hsf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .wait_req    (wait_req),
    .rd_active   (rd_active),
    .done_strobe (done_strobe)
);

// File: tb/hs_reg_fsm_tb.sv
`timescale 1ns/100ps
module hs_reg_fsm_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic wait_req = 1'b0;
    logic rd0, dn0, rd1, dn1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Model phase: 0 idle, 1 read, 2 delay, 3 done
    int    m_ph = 0;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    hs_reg_fsm #(.OUT_STYLE(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .wait_req(wait_req),
        .rd_active(rd0), .done_strobe(dn0));

    hs_reg_fsm #(.OUT_STYLE(1)) u_dut_sb (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .wait_req(wait_req),
        .rd_active(rd1), .done_strobe(dn1));

    function automatic int nxt_ph(int ph, bit s, bit w);
        case (ph)
            0: return s ? 1 : 0;
            1: return 2;
            2: return w ? 1 : 3;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_rd(int ph);
        return (ph == 1) || (ph == 2);
    endfunction

    function automatic bit exp_dn(int ph);
        return ph == 3;
    endfunction

    function automatic string tag_of(int ph, bit r);
        if (!r) return "R1";
        case (ph)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_outputs();
        n_chk++;
        if (rd0 !== exp_rd(m_ph) || dn0 !== exp_dn(m_ph)) begin
            n_bad++;
            $display("FAIL %s style0 rd/ds=%b%b expected %b%b", m_tag, rd0, dn0,
                     exp_rd(m_ph), exp_dn(m_ph));
        end
        n_chk++;
        if (rd1 !== rd0 || dn1 !== dn0) begin
            n_bad++;
            $display("FAIL R7 style1 rd/ds=%b%b expected %b%b", rd1, dn1, rd0, dn0);
        end
        n_chk++;
        if ((rd0 && dn0) || (rd1 && dn1)) begin
            n_bad++;
            $display("FAIL R6 both outputs high: %b%b %b%b expected not both", rd0, dn0, rd1, dn1);
        end
    endtask

    // One cycle: check at negedge, drive, then advance the model at posedge
    task automatic step(bit r, bit s, bit w);
        @(negedge clk);
        check_outputs();
        rst_n = r;
        start_req = s;
        wait_req = w;
        @(posedge clk);
        m_tag = tag_of(m_ph, r);
        m_ph = r ? nxt_ph(m_ph, s, w) : 0;
    endtask

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        // Reset held with requests high: R1
        rst_n = 1'b0; start_req = 1'b1; wait_req = 1'b1;
        @(posedge clk);
        m_ph = 0;
        step(0, 1, 1);
        step(0, 0, 0);
        // Idle hold then start: R2
        step(1, 0, 0);
        step(1, 0, 1);
        step(1, 1, 0);
        // Read ignores inputs: R3; delay exits to done: R4
        step(1, 0, 1);
        step(1, 1, 0);
        // Done ignores held start: R5
        step(1, 1, 1);
        step(1, 1, 0);
        // Long wait loop: R4
        for (int i = 0; i < 8; i++) step(1, 0, 1);
        step(1, 0, 0);
        step(1, 0, 0);
        step(1, 0, 0);
        // Reset mid transaction: R1
        step(1, 1, 0);
        step(1, 0, 1);
        step(0, 1, 1);
        step(1, 0, 0);
        // Random traffic with occasional reset
        for (int i = 0; i < 3000; i++) begin
            bit r, s, w;
            r = ($urandom % 64) != 0;
            s = ($urandom % 3) != 0;
            w = ($urandom % 2) != 0;
            step(r, s, w);
        end
        step(1, 0, 0);
        @(negedge clk);
        check_outputs();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog expired: running expected finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule